// File: doc/BRIEF.md
# Per-core IRQ/FIQ interrupt router

The block collects interrupt requests for four processor cores and produces one normal-priority (IRQ) line and one fast (FIQ) line per core. Each core has four timer request lines and four mailbox-nonzero flags. Two more sources are shared by all cores. The first is an upstream controller, which supplies its own IRQ and FIQ lines. The second is a local-timer request, formed from an enable flag and a pending flag. The block does not hold the mailbox contents or run the timer countdown. Those arrive as level inputs.

Software configures the block through a word-wide register port. For each core there is a timer mask and a mailbox mask. Each mask has an IRQ enable bit and an FIQ enable bit for every source, and the FIQ enable takes precedence. The shared sources are never broadcast. A core-number field steers each one to a single core. Read-only status words show, per core, which sources are driving that core's IRQ and which are driving its FIQ. The core outputs are registered ORs of those words.

Top module: `irq_router`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0 and every mapped register reads 0. Both shared sources therefore route to core 0, and every per-core source is disabled.
- R2: The upstream route register at offset 0x0C holds the IRQ target core in bits 1:0 and the FIQ target core in bits 3:2. A read returns exactly these fields, and every other bit reads 0.
- R3: While `up_irq` is high, bit 8 is set in the IRQ status word of the IRQ target core only. While `up_fiq` is high, bit 8 is set in the FIQ status word of the FIQ target core only.
- R4: The local-timer route register at offset 0x24 keeps 3 bits. Bits 1:0 select the core, and bit 2 selects FIQ (1) or IRQ (0). Status bit 11 of that core is set only while both `lt_ien` and `lt_pend` are high.
- R5: The timer mask of core c is at 0x40+4c and the mailbox mask is at 0x50+4c. Each keeps only bits 7:0. Bit n (n=0..3) is the IRQ enable and bit n+4 is the FIQ enable of source n.
- R6: A source whose FIQ enable is set appears only in the FIQ status word, even when its IRQ enable is also set. A source with neither enable set appears in neither word.
- R7: Timer request n of core c is input bit `tmr_req[4c+n]` and sets status bit n. Mailbox flag n of core c is `mbx_nz[4c+n]` and sets status bit 4+n. The IRQ status word of core c is read at 0x60+4c and the FIQ status word at 0x70+4c. Writes to these offsets are ignored.
- R8: `irq_o[c]` is the OR of the bits of core c's IRQ status word, and `fiq_o[c]` is the OR of the bits of its FIQ status word. Each output is registered, so it follows an input change at the next rising clock edge.
- R9: The following accesses are not decoded: an unmapped offset, an offset with bits 1:0 nonzero, or a `byte_en` value other than 4'hF. Such a read returns 0 and such a write changes nothing. Read data appears in `rdata` one clock after `rd_en`, and `rdata` is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| byte_en | input | 4 | Byte lanes; only 4'hF is decoded |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tmr_req | input | 16 | Per-core timer requests, bit 4c+n |
| mbx_nz | input | 16 | Per-core mailbox nonzero flags, bit 4c+n |
| up_irq | input | 1 | Shared upstream IRQ request |
| up_fiq | input | 1 | Shared upstream FIQ request |
| lt_ien | input | 1 | Local-timer interrupt enable |
| lt_pend | input | 1 | Local-timer pending flag |
| irq_o | output | 4 | Per-core IRQ outputs |
| fiq_o | output | 4 | Per-core FIQ outputs |

## Verification
The assertions assume that every interrupt input is a level synchronous to `clk`, held for at least one full cycle. They also assume that reset is applied before the first input edge that matters. The bench drives all inputs and register accesses only on falling edges, so each request is stable across the rising edge that registers it. The bench also holds reset from time zero, and the checker's single-cycle look-back always finds a post-reset value. The exclusivity properties count bits across all cores. They therefore also depend on the route fields being real core numbers, which the 2-bit fields guarantee for four cores.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W     = 8;
  localparam int GRP_SRCS   = 4;
  localparam int MASK_W     = 2 * GRP_SRCS;
  localparam int BIT_TMR    = 0;
  localparam int BIT_MBX    = 4;
  localparam int BIT_UP     = 8;
  localparam int BIT_LT     = 11;
  localparam logic [ADDR_W-1:0] OFS_UPROUTE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_LTROUTE = 8'h24;
  localparam logic [3:0] WIN_TMASK = 4'h4;
  localparam logic [3:0] WIN_MMASK = 4'h5;
  localparam logic [3:0] WIN_IRQST = 4'h6;
  localparam logic [3:0] WIN_FIQST = 4'h7;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int CW    = 2,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [DW/8-1:0]               byte_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [NCORE-1:0][DW-1:0]      irq_word,
  input  logic [NCORE-1:0][DW-1:0]      fiq_word,
  output logic [DW-1:0]                 rdata,
  output logic [CW-1:0]                 up_irq_core,
  output logic [CW-1:0]                 up_fiq_core,
  output logic [CW:0]                   lt_route,
  output logic [NCORE-1:0][MASK_W-1:0]  tmask,
  output logic [NCORE-1:0][MASK_W-1:0]  mmask
);
  // Each per-core window spans 16 bytes, so at most four cores are decoded.
  logic       acc_ok;
  logic [1:0] idx;
  logic       idx_ok;
  logic [3:0] win;
  logic [DW-1:0] rd_val;

  assign acc_ok = (byte_en == '1) && (addr[1:0] == 2'b00);
  assign idx    = addr[3:2];
  assign idx_ok = int'(idx) < NCORE;
  assign win    = addr[7:4];

  wire unused_wbits = &{1'b0, wdata[DW-1:MASK_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      up_irq_core <= '0;
      up_fiq_core <= '0;
      lt_route    <= '0;
      tmask       <= '0;
      mmask       <= '0;
    end else if (wr_en && acc_ok) begin
      if (addr == OFS_UPROUTE) begin
        up_irq_core <= wdata[CW-1:0];
        up_fiq_core <= wdata[2*CW-1:CW];
      end else if (addr == OFS_LTROUTE) begin
        lt_route <= wdata[CW:0];
      end else if (win == WIN_TMASK && idx_ok) begin
        tmask[idx] <= wdata[MASK_W-1:0];
      end else if (win == WIN_MMASK && idx_ok) begin
        mmask[idx] <= wdata[MASK_W-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (acc_ok) begin
      if (addr == OFS_UPROUTE)
        rd_val[2*CW-1:0] = {up_fiq_core, up_irq_core};
      else if (addr == OFS_LTROUTE)
        rd_val[CW:0] = lt_route;
      else if (idx_ok) begin
        case (win)
          WIN_TMASK: rd_val[MASK_W-1:0] = tmask[idx];
          WIN_MMASK: rd_val[MASK_W-1:0] = mmask[idx];
          WIN_IRQST: rd_val = irq_word[idx];
          WIN_FIQST: rd_val = fiq_word[idx];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_val : '0;
  end
endmodule

// File: rtl/irq_router_core_map.sv
module irq_router_core_map
  import irq_router_pkg::*;
#(
  parameter int CORE_ID = 0,
  parameter int CW      = 2,
  parameter int DW      = 32
) (
  input  logic [GRP_SRCS-1:0] tmr,
  input  logic [GRP_SRCS-1:0] mbx,
  input  logic [MASK_W-1:0]   tmask,
  input  logic [MASK_W-1:0]   mmask,
  input  logic                up_irq,
  input  logic                up_fiq,
  input  logic [CW-1:0]       up_irq_core,
  input  logic [CW-1:0]       up_fiq_core,
  input  logic                lt_req,
  input  logic [CW:0]         lt_route,
  output logic [DW-1:0]       irq_word,
  output logic [DW-1:0]       fiq_word
);
  localparam logic [CW-1:0] ME = CW'(CORE_ID);

  always_comb begin
    irq_word = '0;
    fiq_word = '0;
    for (int n = 0; n < GRP_SRCS; n++) begin
      fiq_word[BIT_TMR+n] = tmr[n] & tmask[n+GRP_SRCS];
      irq_word[BIT_TMR+n] = tmr[n] & tmask[n] & ~tmask[n+GRP_SRCS];
      fiq_word[BIT_MBX+n] = mbx[n] & mmask[n+GRP_SRCS];
      irq_word[BIT_MBX+n] = mbx[n] & mmask[n] & ~mmask[n+GRP_SRCS];
    end
    irq_word[BIT_UP] = up_irq && (up_irq_core == ME);
    fiq_word[BIT_UP] = up_fiq && (up_fiq_core == ME);
    irq_word[BIT_LT] = lt_req && (lt_route[CW-1:0] == ME) && !lt_route[CW];
    fiq_word[BIT_LT] = lt_req && (lt_route[CW-1:0] == ME) &&  lt_route[CW];
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [DW/8-1:0]           byte_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [NCORE*GRP_SRCS-1:0] tmr_req,
  input  logic [NCORE*GRP_SRCS-1:0] mbx_nz,
  input  logic                      up_irq,
  input  logic                      up_fiq,
  input  logic                      lt_ien,
  input  logic                      lt_pend,
  output logic [NCORE-1:0]          irq_o,
  output logic [NCORE-1:0]          fiq_o
);
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [CW-1:0]                up_irq_core, up_fiq_core;
  logic [CW:0]                  lt_route;
  logic [NCORE-1:0][MASK_W-1:0] tmask, mmask;
  logic [NCORE-1:0][DW-1:0]     irq_word, fiq_word;
  logic                         lt_req;

  assign lt_req = lt_ien & lt_pend;

  irq_router_regs #(.NCORE(NCORE), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
    .addr(addr), .wdata(wdata), .irq_word(irq_word), .fiq_word(fiq_word),
    .rdata(rdata), .up_irq_core(up_irq_core), .up_fiq_core(up_fiq_core),
    .lt_route(lt_route), .tmask(tmask), .mmask(mmask)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    irq_router_core_map #(.CORE_ID(c), .CW(CW), .DW(DW)) u_map (
      .tmr(tmr_req[c*GRP_SRCS +: GRP_SRCS]),
      .mbx(mbx_nz[c*GRP_SRCS +: GRP_SRCS]),
      .tmask(tmask[c]), .mmask(mmask[c]),
      .up_irq(up_irq), .up_fiq(up_fiq),
      .up_irq_core(up_irq_core), .up_fiq_core(up_fiq_core),
      .lt_req(lt_req), .lt_route(lt_route),
      .irq_word(irq_word[c]), .fiq_word(fiq_word[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_o[c] <= 1'b0;
        fiq_o[c] <= 1'b0;
      end else begin
        irq_o[c] <= |irq_word[c];
        fiq_o[c] <= |fiq_word[c];
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  up_irq,
  input logic                  up_fiq,
  input logic                  lt_ien,
  input logic                  lt_pend,
  input logic [NCORE-1:0]      irq_o,
  input logic [NCORE-1:0]      fiq_o,
  input logic [NCORE-1:0][DW-1:0] irq_word,
  input logic [NCORE-1:0][DW-1:0] fiq_word
);
  logic [NCORE-1:0] irq_any, fiq_any, up_i_col, up_f_col, lt_i_col, lt_f_col;

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      irq_any[c]  = irq_word[c] != '0;
      fiq_any[c]  = fiq_word[c] != '0;
      up_i_col[c] = irq_word[c][BIT_UP];
      up_f_col[c] = fiq_word[c][BIT_UP];
      lt_i_col[c] = irq_word[c][BIT_LT];
      lt_f_col[c] = fiq_word[c][BIT_LT];
    end
  end

  // R8
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(irq_any)) && (fiq_o == $past(fiq_any)));

  // R3
  up_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(up_i_col) == (up_irq ? 1 : 0));

  // R3
  up_fiq_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(up_f_col) == (up_fiq ? 1 : 0));

  // R4
  lt_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({lt_i_col, lt_f_col}) == ((lt_ien && lt_pend) ? 1 : 0));

  for (genvar c = 0; c < NCORE; c++) begin : g_excl
    // R6
    fiq_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_word[c][7:0] & fiq_word[c][7:0]) == 8'h00);
  end
endmodule

bind irq_router irq_router_chk #(.NCORE(NCORE), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .up_irq(up_irq), .up_fiq(up_fiq),
  .lt_ien(lt_ien), .lt_pend(lt_pend), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_word(irq_word), .fiq_word(fiq_word)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  byte_en = 4'hF;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tmr_req = '0, mbx_nz = '0;
  logic        up_irq = 1'b0, up_fiq = 1'b0, lt_ien = 1'b0, lt_pend = 1'b0;
  logic [3:0]  irq_o, fiq_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_req(tmr_req),
    .mbx_nz(mbx_nz), .up_irq(up_irq), .up_fiq(up_fiq), .lt_ien(lt_ien),
    .lt_pend(lt_pend), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {tmr_req, mbx_nz, up_irq, up_fiq, lt_ien, lt_pend, exp irq_o, exp fiq_o}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 4'b0000, 4'b0000, 4'b0000},
    {16'h0001, 16'h0000, 4'b0000, 4'b0000, 4'b0001},
    {16'h0020, 16'h0000, 4'b0000, 4'b0010, 4'b0000},
    {16'h0100, 16'h0000, 4'b0000, 4'b0000, 4'b0000},
    {16'h8000, 16'h0000, 4'b0000, 4'b0000, 4'b1000},
    {16'h0000, 16'h0010, 4'b0000, 4'b0000, 4'b0010},
    {16'h0000, 16'h0400, 4'b0000, 4'b0100, 4'b0000},
    {16'h0000, 16'h0001, 4'b0000, 4'b0000, 4'b0000},
    {16'h0000, 16'h0000, 4'b1000, 4'b0100, 4'b0000},
    {16'h0000, 16'h0000, 4'b0100, 4'b0000, 4'b0010},
    {16'h0000, 16'h0000, 4'b0010, 4'b0000, 4'b0000},
    {16'h0000, 16'h0000, 4'b0011, 4'b0000, 4'b1000},
    {16'h0000, 16'h0000, 4'b0001, 4'b0000, 4'b0000},
    {16'h0021, 16'h0000, 4'b1000, 4'b0110, 4'b0001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; byte_en = be;
    @(negedge clk);
    wr_en = 1'b0; byte_en = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    rd_en = 1'b1; addr = a; byte_en = be;
    @(negedge clk);
    rd_en = 1'b0; byte_en = 4'hF;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_o after reset", {28'd0, irq_o}, 32'h0);
    check("R1 fiq_o after reset", {28'd0, fiq_o}, 32'h0);
    rd_chk("R1 uproute", 8'h0C, 32'h0);
    rd_chk("R1 ltroute", 8'h24, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 tmask", 8'h40 + 8'(4*c), 32'h0);
      rd_chk("R1 mmask", 8'h50 + 8'(4*c), 32'h0);
    end

    // R2 field readback
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R2 uproute all ones", 8'h0C, 32'h0000_000F);
    // R4 three bits kept
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R4 ltroute width", 8'h24, 32'h0000_0007);
    // R5 eight bits kept
    wr(8'h44, 32'h0000_01FF);
    rd_chk("R5 tmask width", 8'h44, 32'h0000_00FF);
    wr(8'h5C, 32'hABCD_1234);
    rd_chk("R5 mmask width", 8'h5C, 32'h0000_0034);

    // table configuration
    wr(8'h0C, 32'h6);     // IRQ core 2, FIQ core 1
    rd_chk("R2 uproute fields", 8'h0C, 32'h6);
    wr(8'h24, 32'h7);     // core 3, FIQ
    wr(8'h40, 32'h11); wr(8'h44, 32'h02); wr(8'h48, 32'h00); wr(8'h4C, 32'h80);
    wr(8'h50, 32'h00); wr(8'h54, 32'h10); wr(8'h58, 32'h04); wr(8'h5C, 32'h00);

    // R3 R4 R6 R7 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {tmr_req, mbx_nz, up_irq, up_fiq, lt_ien, lt_pend} = VEC[i][43:8];
      @(negedge clk);
      check($sformatf("R8 vec %0d irq_o", i), {28'd0, irq_o}, {28'd0, VEC[i][7:4]});
      check($sformatf("R8 vec %0d fiq_o", i), {28'd0, fiq_o}, {28'd0, VEC[i][3:0]});
    end

    // R7 status word contents and layout
    {tmr_req, mbx_nz, up_irq, up_fiq, lt_ien, lt_pend} = '0;
    tmr_req = 16'h0021; mbx_nz = 16'h0410; up_irq = 1'b1; up_fiq = 1'b1;
    lt_ien = 1'b1; lt_pend = 1'b1;
    rd_chk("R7 irq status core1 timer bit1", 8'h64, 32'h0000_0002);
    rd_chk("R7 fiq status core1 mbox bit4 + up bit8", 8'h74, 32'h0000_0110);
    rd_chk("R3 irq status core2 up bit8 + mbox bit6", 8'h68, 32'h0000_0140);
    rd_chk("R6 fiq status core0 timer bit0", 8'h70, 32'h0000_0001);
    rd_chk("R6 irq status core0 empty", 8'h60, 32'h0);
    rd_chk("R4 fiq status core3 lt bit11", 8'h7C, 32'h0000_0800);
    wr(8'h24, 32'h3);     // core 3, IRQ
    rd_chk("R4 irq status core3 lt bit11", 8'h6C, 32'h0000_0800);
    rd_chk("R4 fiq status core3 cleared", 8'h7C, 32'h0);
    // R7 status write ignored
    wr(8'h64, 32'hFFFF_FFFF);
    rd_chk("R7 status write ignored", 8'h64, 32'h0000_0002);

    // R9 undecoded accesses
    rd_chk("R9 unmapped read", 8'h30, 32'h0);
    rd(8'h0C, v, 4'h1);
    check("R9 partial read", v, 32'h0);
    rd_chk("R9 misaligned read", 8'h0D, 32'h0);
    wr(8'h0C, 32'h0, 4'h3);
    rd_chk("R9 partial write ignored", 8'h0C, 32'h6);
    wr(8'h0E, 32'h0);
    rd_chk("R9 misaligned write ignored", 8'h0C, 32'h6);
    wr(8'h10, 32'h0); wr(8'h80, 32'hFF);
    rd_chk("R9 unmapped write ignored", 8'h0C, 32'h6);
    @(negedge clk);
    check("R9 rdata idle zero", rdata, 32'h0);

    // R1 mid-run reset: up_irq lands on core 0, masked sources silent
    tmr_req = 16'hFFFF; mbx_nz = 16'hFFFF; up_irq = 1'b1; up_fiq = 1'b0;
    lt_ien = 1'b0; lt_pend = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 irq_o in reset", {28'd0, irq_o}, 32'h0);
    rst = 1'b0;
    settle();
    check("R1 up_irq to core0 after reset", {28'd0, irq_o}, 32'h1);
    check("R1 masked after reset fiq_o", {28'd0, fiq_o}, 32'h0);
    rd_chk("R1 uproute after reset", 8'h0C, 32'h0);
    rd_chk("R1 tmask after reset", 8'h44, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule